// File: doc/BRIEF.md
# Flash Controller Two-Key Unlock Guard

This block decides whether software may modify the flash controller's control register, and whether option-byte erase and program operations are allowed. Software opens the controller by writing two fixed 32-bit keys, in a fixed order, to the main key port. Any mistake in that sequence leaves the controller closed until the next reset. A second key port accepts the same two-key sequence and turns on the option write enable. The option path forgives mistakes and accepts any number of retries.

The block drives a `lock` flag, a `hard_lock` flag and `opt_wr_en`. It also drives a `ctl_wr_grant` strobe that passes an accepted control-register write on to the rest of the controller. A granted write can set the lock again. A granted write can also clear the option write enable, but no write can set it. Erase and program sequencing and the storage array are handled elsewhere.

Top module: `flash_key_guard`

## Requirements
- R1: After reset, `lock`=1, `hard_lock`=0 and `opt_wr_en`=0.
- R2: While `lock`=1, `ctl_wr_grant` stays 0 in the cycle `ctl_wr_en` is high. Such a write changes neither `lock` nor `opt_wr_en`.
- R3: While locked and not hard-locked, a main-key write of 0x45670123 followed by a main-key write of 0xCDEF89AB clears `lock`. The flag reads 0 one clock edge after the second write.
- R4: While `lock`=1, a main-key write that breaks the sequence sets `hard_lock` and keeps `lock` at 1. Breaking the sequence means a first write other than 0x45670123, or a second write other than 0xCDEF89AB. After that, no key sequence clears `lock`. Only reset clears `hard_lock`.
- R5: While `lock`=0, main-key writes of any value have no effect on `lock` or `hard_lock`.
- R6: A granted control write with `ctl_lock_set`=1 sets `lock` at the next edge without setting `hard_lock`. The normal key sequence can then clear `lock` again.
- R7: While `lock`=0, an option-key write of 0x45670123 followed by an option-key write of 0xCDEF89AB sets `opt_wr_en` at the edge of the second write.
- R8: An option-key write of 0x45670123 followed by any other value restarts the option sequence and leaves `opt_wr_en` unchanged. A fresh 0x45670123 re-arms the sequence. Option-key mistakes never set `hard_lock` and never block a later correct sequence.
- R9: While `lock`=1, a complete option-key sequence does not set `opt_wr_en`.
- R10: A granted control write with `ctl_optwe_val`=0 clears `opt_wr_en`. A granted write with `ctl_optwe_val`=1 does not set it.
- R11: Writing the option-key sequence again while `opt_wr_en`=1 leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_wr_en | input | 1 | Write strobe for the main key register |
| key_wdata | input | 32 | Data of the main key write |
| optkey_wr_en | input | 1 | Write strobe for the option key register |
| optkey_wdata | input | 32 | Data of the option key write |
| ctl_wr_en | input | 1 | Control-register write strobe |
| ctl_lock_set | input | 1 | Lock field value of the control write (1 relocks) |
| ctl_optwe_val | input | 1 | Option write-enable field value of the control write (0 clears) |
| lock | output | 1 | Control register locked |
| hard_lock | output | 1 | Locked until reset after a bad main-key sequence |
| opt_wr_en | output | 1 | Option-byte operations allowed |
| ctl_wr_grant | output | 1 | Control write accepted this cycle |

## Verification
`ctl_wr_grant` is combinational. The bench reads it in the same cycle the control write is driven, shortly after the falling edge. `lock`, `hard_lock` and `opt_wr_en` are registered and move at the rising edge that samples the write. Every stimulus task drives on a falling edge and holds the write for one full cycle. Each check is taken at the following falling edge, when exactly one rising edge has passed. Negative checks, such as a rejected option sequence or a key write while open, are read at that same point, before the next stimulus starts.

// File: rtl/key_guard_pkg.sv
package key_guard_pkg;
  parameter int KEY_W = 32;
  parameter logic [KEY_W-1:0] UNLOCK_K1 = 32'h4567_0123;
  parameter logic [KEY_W-1:0] UNLOCK_K2 = 32'hCDEF_89AB;

  typedef enum logic [1:0] {
    MK_WAIT1 = 2'd0,
    MK_WAIT2 = 2'd1,
    MK_OPEN  = 2'd2,
    MK_DEAD  = 2'd3
  } mk_state_e;

  function automatic logic is_first_key(input logic [KEY_W-1:0] d);
    return d == UNLOCK_K1;
  endfunction

  function automatic logic is_second_key(input logic [KEY_W-1:0] d);
    return d == UNLOCK_K2;
  endfunction
endpackage

// File: rtl/ctl_write_gate.sv
module ctl_write_gate (
  input  logic ctl_wr_en,
  input  logic ctl_lock_set,
  input  logic ctl_optwe_val,
  input  logic lock,
  output logic grant,
  output logic sw_lock_set,
  output logic sw_optwe_clr
);
  always_comb begin
    grant        = ctl_wr_en & ~lock;
    sw_lock_set  = grant & ctl_lock_set;
    sw_optwe_clr = grant & ~ctl_optwe_val;
  end
endmodule

// File: rtl/main_key_fsm.sv
module main_key_fsm
  import key_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr_en,
  input  logic [KEY_W-1:0] key_wdata,
  input  logic             sw_lock_set,
  output logic             lock,
  output logic             hard_lock
);
  mk_state_e state_q, state_d;
  logic key_ok_step;
  logic key_bad;
  logic key_done;

  // Events named for the checks below.
  always_comb begin
    key_ok_step = 1'b0;
    key_bad     = 1'b0;
    key_done    = 1'b0;
    if (key_wr_en) begin
      unique case (state_q)
        MK_WAIT1: begin
          key_ok_step = is_first_key(key_wdata);
          key_bad     = ~is_first_key(key_wdata);
        end
        MK_WAIT2: begin
          key_done = is_second_key(key_wdata);
          key_bad  = ~is_second_key(key_wdata);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MK_WAIT1: if (key_bad) state_d = MK_DEAD;
                else if (key_ok_step) state_d = MK_WAIT2;
      MK_WAIT2: if (key_bad) state_d = MK_DEAD;
                else if (key_done) state_d = MK_OPEN;
      MK_OPEN:  if (sw_lock_set) state_d = MK_WAIT1;
      MK_DEAD:  state_d = MK_DEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MK_WAIT1;
    else        state_q <= state_d;
  end

  assign lock      = (state_q != MK_OPEN);
  assign hard_lock = (state_q == MK_DEAD);

  p_hard_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lock |=> hard_lock);
  p_unlock_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(key_wr_en && is_second_key(key_wdata)));
  p_open_ignores_keys_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock && key_wr_en && !sw_lock_set) |=> (!lock && !hard_lock));
  p_relock_soft_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock && sw_lock_set) |=> (lock && !hard_lock));
endmodule

// File: rtl/opt_key_fsm.sv
module opt_key_fsm
  import key_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             optkey_wr_en,
  input  logic [KEY_W-1:0] optkey_wdata,
  input  logic             lock,
  input  logic             sw_optwe_clr,
  output logic             opt_we
);
  logic armed_q;
  logic opt_grant;
  logic opt_restart;

  always_comb begin
    opt_grant   = optkey_wr_en & armed_q & is_second_key(optkey_wdata) & ~lock;
    opt_restart = optkey_wr_en & ~is_first_key(optkey_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      opt_we  <= 1'b0;
    end else begin
      if (optkey_wr_en) armed_q <= is_first_key(optkey_wdata);
      if (sw_optwe_clr)   opt_we <= 1'b0;
      else if (opt_grant) opt_we <= 1'b1;
    end
  end

  p_optwe_set_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(opt_we) |-> $past(optkey_wr_en && is_second_key(optkey_wdata) && !lock));
  p_optwe_clear_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(opt_we) |-> $past(sw_optwe_clr));
  p_restart_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    opt_restart |=> !armed_q);
  p_locked_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !opt_we) |=> !opt_we);
endmodule

// File: rtl/flash_key_guard.sv
module flash_key_guard
  import key_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr_en,
  input  logic [KEY_W-1:0] key_wdata,
  input  logic             optkey_wr_en,
  input  logic [KEY_W-1:0] optkey_wdata,
  input  logic             ctl_wr_en,
  input  logic             ctl_lock_set,
  input  logic             ctl_optwe_val,
  output logic             lock,
  output logic             hard_lock,
  output logic             opt_wr_en,
  output logic             ctl_wr_grant
);
  logic sw_lock_set;
  logic sw_optwe_clr;

  ctl_write_gate u_gate (
    .ctl_wr_en    (ctl_wr_en),
    .ctl_lock_set (ctl_lock_set),
    .ctl_optwe_val(ctl_optwe_val),
    .lock         (lock),
    .grant        (ctl_wr_grant),
    .sw_lock_set  (sw_lock_set),
    .sw_optwe_clr (sw_optwe_clr)
  );

  main_key_fsm u_main (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr_en  (key_wr_en),
    .key_wdata  (key_wdata),
    .sw_lock_set(sw_lock_set),
    .lock       (lock),
    .hard_lock  (hard_lock)
  );

  opt_key_fsm u_opt (
    .clk         (clk),
    .rst_n       (rst_n),
    .optkey_wr_en(optkey_wr_en),
    .optkey_wdata(optkey_wdata),
    .lock        (lock),
    .sw_optwe_clr(sw_optwe_clr),
    .opt_we      (opt_wr_en)
  );

  p_locked_ctl_keeps_optwe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && ctl_wr_en && opt_wr_en) |=> opt_wr_en);
  p_locked_ctl_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && ctl_wr_en) |-> !ctl_wr_grant);
endmodule

// File: tb/tb_flash_key_guard.sv
module tb_flash_key_guard;
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_wr_en = 1'b0;
  logic [31:0] key_wdata = '0;
  logic optkey_wr_en = 1'b0;
  logic [31:0] optkey_wdata = '0;
  logic ctl_wr_en = 1'b0;
  logic ctl_lock_set = 1'b0;
  logic ctl_optwe_val = 1'b0;
  logic lock, hard_lock, opt_wr_en, ctl_wr_grant;

  int n_run = 0;
  int n_fail = 0;
  logic grant_seen;

  always #4 clk = ~clk;

  flash_key_guard dut (
    .clk(clk), .rst_n(rst_n),
    .key_wr_en(key_wr_en), .key_wdata(key_wdata),
    .optkey_wr_en(optkey_wr_en), .optkey_wdata(optkey_wdata),
    .ctl_wr_en(ctl_wr_en), .ctl_lock_set(ctl_lock_set), .ctl_optwe_val(ctl_optwe_val),
    .lock(lock), .hard_lock(hard_lock), .opt_wr_en(opt_wr_en), .ctl_wr_grant(ctl_wr_grant)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_main(input logic [31:0] d);
    key_wr_en = 1'b1; key_wdata = d;
    @(negedge clk);
    key_wr_en = 1'b0; key_wdata = '0;
  endtask

  task automatic wr_opt(input logic [31:0] d);
    optkey_wr_en = 1'b1; optkey_wdata = d;
    @(negedge clk);
    optkey_wr_en = 1'b0; optkey_wdata = '0;
  endtask

  task automatic wr_ctl(input logic lk, input logic owe);
    ctl_wr_en = 1'b1; ctl_lock_set = lk; ctl_optwe_val = owe;
    #1 grant_seen = ctl_wr_grant;
    @(negedge clk);
    ctl_wr_en = 1'b0; ctl_lock_set = 1'b0; ctl_optwe_val = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(lock, 1'b1, "R1 lock after reset");
    chk(hard_lock, 1'b0, "R1 hard_lock after reset");
    chk(opt_wr_en, 1'b0, "R1 opt_wr_en after reset");
  endtask

  task automatic t_locked_ctl();
    do_reset();
    wr_ctl(1'b0, 1'b1);
    chk(grant_seen, 1'b0, "R2 grant while locked");
    chk(lock, 1'b1, "R2 lock kept after locked write");
    chk(opt_wr_en, 1'b0, "R2 opt_wr_en not set by locked write");
  endtask

  task automatic t_unlock();
    do_reset();
    wr_main(K1);
    chk(lock, 1'b1, "R3 still locked after first key");
    wr_main(K2);
    chk(lock, 1'b0, "R3 unlocked after second key");
    chk(hard_lock, 1'b0, "R3 no hard lock");
    wr_ctl(1'b0, 1'b0);
    chk(grant_seen, 1'b1, "R3 grant once open");
  endtask

  task automatic t_open_keys();
    do_reset();
    wr_main(K1); wr_main(K2);
    wr_main(32'hDEAD_BEEF);
    chk(lock, 1'b0, "R5 lock after junk while open");
    chk(hard_lock, 1'b0, "R5 hard_lock after junk while open");
    wr_main(K1);
    chk(lock, 1'b0, "R5 lock after key1 while open");
  endtask

  task automatic t_sw_relock();
    do_reset();
    wr_main(K1); wr_main(K2);
    wr_ctl(1'b1, 1'b0);
    chk(grant_seen, 1'b1, "R6 relock write granted");
    chk(lock, 1'b1, "R6 lock set by software");
    chk(hard_lock, 1'b0, "R6 soft lock not hard");
    wr_main(K1); wr_main(K2);
    chk(lock, 1'b0, "R6 unlock after software lock");
  endtask

  task automatic t_hard_first();
    do_reset();
    wr_main(32'h0000_0001);
    chk(hard_lock, 1'b1, "R4 hard lock on bad first key");
    chk(lock, 1'b1, "R4 lock held on bad first key");
    wr_main(K1); wr_main(K2);
    chk(lock, 1'b1, "R4 keys cannot unlock after hard lock");
    do_reset();
    chk(hard_lock, 1'b0, "R4 reset clears hard lock");
    wr_main(K1); wr_main(K2);
    chk(lock, 1'b0, "R4 unlock works after reset");
  endtask

  task automatic t_hard_second();
    do_reset();
    wr_main(K1); wr_main(K1);
    chk(hard_lock, 1'b1, "R4 hard lock on bad second key");
    wr_opt(K1); wr_opt(K2);
    chk(opt_wr_en, 1'b0, "R9 option keys under hard lock");
  endtask

  task automatic t_opt_locked();
    do_reset();
    wr_opt(K1); wr_opt(K2);
    chk(opt_wr_en, 1'b0, "R9 option keys while locked");
    wr_main(K1); wr_main(K2);
    chk(opt_wr_en, 1'b0, "R9 stale option sequence does not apply");
  endtask

  task automatic t_opt_ok();
    do_reset();
    wr_main(K1); wr_main(K2);
    wr_ctl(1'b0, 1'b1);
    chk(opt_wr_en, 1'b0, "R10 software cannot set opt_wr_en");
    wr_opt(K1);
    chk(opt_wr_en, 1'b0, "R7 not enabled after first option key");
    wr_opt(K2);
    chk(opt_wr_en, 1'b1, "R7 enabled after option keys");
    wr_opt(K1); wr_opt(K2);
    chk(opt_wr_en, 1'b1, "R11 stays enabled on repeat");
    wr_opt(32'h1111_2222);
    chk(opt_wr_en, 1'b1, "R11 wrong option value keeps enable");
    wr_ctl(1'b0, 1'b1);
    chk(opt_wr_en, 1'b1, "R10 write of 1 keeps enable");
    wr_ctl(1'b0, 1'b0);
    chk(opt_wr_en, 1'b0, "R10 write of 0 clears enable");
  endtask

  task automatic t_opt_wrong();
    do_reset();
    wr_main(K1); wr_main(K2);
    wr_opt(K1); wr_opt(32'h1234_5678); wr_opt(K2);
    chk(opt_wr_en, 1'b0, "R8 broken option sequence rejected");
    wr_opt(K2);
    chk(opt_wr_en, 1'b0, "R8 lone second option key rejected");
    chk(hard_lock, 1'b0, "R8 option mistakes never hard lock");
    chk(lock, 1'b0, "R8 option mistakes keep main open");
    wr_opt(K1); wr_opt(K1); wr_opt(K2);
    chk(opt_wr_en, 1'b1, "R8 fresh key1 re-arms and retry succeeds");
  endtask

  initial begin
    t_reset_state();
    t_locked_ctl();
    t_unlock();
    t_open_keys();
    t_sw_relock();
    t_hard_first();
    t_hard_second();
    t_opt_locked();
    t_opt_ok();
    t_opt_wrong();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule